// File: doc/BRIEF.md
# Relocation and limit address translator

This block sits between a processor's load/store port and memory. It confines one user process to a single contiguous region of physical memory. Each logical address from the processor is first compared with a limit value. An address that passes the check is offset by a relocation base and sent to memory as a physical address. An address that fails the check never reaches memory. Instead, the block raises a trap and reports the offending logical address, so the supervisor can handle the fault. This keeps the resident supervisor code in low memory, and every other region, out of the process's reach. The process itself only ever sees logical addresses.

The relocation base and the limit are held in two registers. A small write port loads them, and that port takes effect only while the privileged-mode input is high. The compare and the add are registered, so translation takes one cycle. The processor and memory sides both use valid/ready handshakes. When memory is not ready, the stall propagates back to the processor side.

Top module: `reloc_limit_xlate`

## Requirements
- R1: After reset, `mem_valid` and `trap_pulse` are 0 and `cpu_ready` is 1. The relocation base resets to 0 and the limit resets to 0, so any access made before configuration traps.
- R2: When a request with `cpu_laddr` strictly less than the limit is accepted, `mem_valid` rises with `mem_paddr` = `cpu_laddr` + relocation base.
- R3: When a request with `cpu_laddr` equal to or above the limit is accepted, `trap_pulse` is high for exactly one cycle with `trap_laddr` = that address, and no memory request is issued for it.
- R4: The translation result, either the memory request or the trap, appears in the cycle right after the accepting clock edge.
- R5: While `mem_valid` is 1 and `mem_ready` is 0, `mem_paddr` holds steady and `cpu_ready` is 0, so no new request is accepted.
- R6: A write with `cfg_we`=1 updates a register only while `priv_mode`=1; writes made while `priv_mode`=0 are ignored. The select encoding is: `cfg_sel`=0 loads the relocation base from all PADDR_W bits of `cfg_wdata`; `cfg_sel`=1 loads the limit from bits [LADDR_W-1:0].
- R7: A register write in the same cycle as an accepted request does not affect that request; it applies from the next accepted request onward.
- R8: The addition wraps modulo 2^PADDR_W.
- R9: With `mem_ready` held high, one request can be accepted on every cycle, with no bubbles, for both legal and trapping requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | High while the processor runs privileged code |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = relocation base, 1 = limit |
| cfg_wdata | input | PADDR_W | Write data |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_laddr | input | LADDR_W | Logical address of the request |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_paddr | output | PADDR_W | Physical address |
| trap_pulse | output | 1 | One-cycle addressing-error trap |
| trap_laddr | output | LADDR_W | Logical address that caused the trap |

## Verification
Some properties are checked by assertions on every cycle:
- an accepted in-bound request always produces a memory request on the next cycle;
- an accepted out-of-bound request always produces a trap carrying its own address;
- a stalled memory request holds its address and blocks the processor side;
- user-mode cycles never change the registers.

Other behaviour can only be shown by the bench's directed scenarios, because each needs a specific value or ordering:
- the exact physical address produced, including the wrap at the top of physical space;
- the equal-to-limit boundary;
- the ordering of a write against a translation accepted in the same cycle;
- full throughput across mixed legal and trapping requests.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
   typedef enum logic {
      SEL_BASE  = 1'b0,
      SEL_BOUND = 1'b1
   } cfg_sel_e;
endpackage

// File: rtl/rlx_cfg_regs.sv
module rlx_cfg_regs
   import rlx_pkg::*;
#(
   parameter int unsigned     LADDR_W   = 16,
   parameter int unsigned     PADDR_W   = 20,
   parameter longint unsigned BASE_RST  = 0,
   parameter longint unsigned BOUND_RST = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               priv_mode,
   input  logic               we,
   input  logic               sel,
   input  logic [PADDR_W-1:0] wdata,
   output logic [PADDR_W-1:0] base_q,
   output logic [LADDR_W-1:0] bound_q
);
   logic     wr_ok;
   cfg_sel_e target;

   assign wr_ok  = we & priv_mode;
   assign target = cfg_sel_e'(sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= PADDR_W'(BASE_RST);
         bound_q <= LADDR_W'(BOUND_RST);
      end else if (wr_ok) begin
         if (target == SEL_BASE) base_q  <= wdata;
         else                    bound_q <= wdata[LADDR_W-1:0];
      end
   end

   AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !priv_mode |=> ($stable(base_q) && $stable(bound_q))); // R6
endmodule

// File: rtl/rlx_check.sv
module rlx_check #(
   parameter int unsigned LADDR_W = 16,
   parameter int unsigned PADDR_W = 20
) (
   input  logic [LADDR_W-1:0] laddr,
   input  logic [PADDR_W-1:0] base,
   input  logic [LADDR_W-1:0] bound,
   output logic               in_range,
   output logic [PADDR_W-1:0] paddr
);
   localparam int unsigned EXT_W = PADDR_W - LADDR_W;

   logic [PADDR_W-1:0] laddr_ext;

   if (LADDR_W < 1) begin : g_bad_lw
      $error("rlx_check: LADDR_W must be at least 1");
   end
   if (PADDR_W < LADDR_W) begin : g_bad_pw
      $error("rlx_check: PADDR_W must not be narrower than LADDR_W");
   end

   if (EXT_W == 0) begin : g_same_w
      assign laddr_ext = laddr;
   end else begin : g_wide_w
      assign laddr_ext = {{EXT_W{1'b0}}, laddr};
   end

   // Strict less-than on the untranslated address; sum wraps in PADDR_W bits.
   assign in_range = (laddr < bound);
   assign paddr    = laddr_ext + base;
endmodule

// File: rtl/rlx_stage.sv
module rlx_stage #(
   parameter int unsigned LADDR_W = 16,
   parameter int unsigned PADDR_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_valid,
   output logic               cpu_ready,
   input  logic               in_range,
   input  logic [LADDR_W-1:0] laddr,
   input  logic [PADDR_W-1:0] paddr_in,
   output logic               mem_valid,
   input  logic               mem_ready,
   output logic [PADDR_W-1:0] mem_paddr,
   output logic               trap_pulse,
   output logic [LADDR_W-1:0] trap_laddr
);
   logic take;

   assign cpu_ready = ~mem_valid | mem_ready;
   assign take      = cpu_valid & cpu_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid  <= 1'b0;
         mem_paddr  <= '0;
         trap_pulse <= 1'b0;
         trap_laddr <= '0;
      end else begin
         trap_pulse <= take & ~in_range;
         if (take & ~in_range) trap_laddr <= laddr;
         if (take & in_range) begin
            mem_valid <= 1'b1;
            mem_paddr <= paddr_in;
         end else if (mem_ready) begin
            mem_valid <= 1'b0;
         end
      end
   end

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_paddr))); // R5
   AST_STALL_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |-> !cpu_ready); // R5
   AST_TRAP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> $past(cpu_valid && cpu_ready)); // R3
endmodule

// File: rtl/reloc_limit_xlate.sv
module reloc_limit_xlate #(
   parameter int unsigned     LADDR_W   = 16,
   parameter int unsigned     PADDR_W   = 20,
   parameter longint unsigned BASE_RST  = 0,
   parameter longint unsigned BOUND_RST = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               priv_mode,
   input  logic               cfg_we,
   input  logic               cfg_sel,
   input  logic [PADDR_W-1:0] cfg_wdata,
   input  logic               cpu_valid,
   output logic               cpu_ready,
   input  logic [LADDR_W-1:0] cpu_laddr,
   output logic               mem_valid,
   input  logic               mem_ready,
   output logic [PADDR_W-1:0] mem_paddr,
   output logic               trap_pulse,
   output logic [LADDR_W-1:0] trap_laddr
);
   logic [PADDR_W-1:0] base_q;
   logic [LADDR_W-1:0] bound_q;
   logic               in_range;
   logic [PADDR_W-1:0] paddr_c;

   rlx_cfg_regs #(
      .LADDR_W(LADDR_W), .PADDR_W(PADDR_W),
      .BASE_RST(BASE_RST), .BOUND_RST(BOUND_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
      .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .base_q(base_q), .bound_q(bound_q)
   );

   rlx_check #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_check (
      .laddr(cpu_laddr), .base(base_q), .bound(bound_q),
      .in_range(in_range), .paddr(paddr_c)
   );

   rlx_stage #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .in_range(in_range), .laddr(cpu_laddr), .paddr_in(paddr_c),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_paddr(mem_paddr),
      .trap_pulse(trap_pulse), .trap_laddr(trap_laddr)
   );

   AST_LEGAL_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && (cpu_laddr < bound_q)) |=> (mem_valid && !trap_pulse)); // R2
   AST_ILLEGAL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_valid && cpu_ready && (cpu_laddr >= bound_q))
         |=> (trap_pulse && (trap_laddr == $past(cpu_laddr)))); // R3
   AST_TRAP_ABOVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> (trap_laddr >= $past(bound_q))); // R3
endmodule

// File: tb/reloc_limit_xlate_test.sv
module reloc_limit_xlate_test;
   localparam int LW = 16;
   localparam int PW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          priv_mode = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [PW-1:0] cfg_wdata = '0;
   logic          cpu_valid = 1'b0;
   logic          cpu_ready;
   logic [LW-1:0] cpu_laddr = '0;
   logic          mem_valid;
   logic          mem_ready = 1'b1;
   logic [PW-1:0] mem_paddr;
   logic          trap_pulse;
   logic [LW-1:0] trap_laddr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   reloc_limit_xlate #(.LADDR_W(LW), .PADDR_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_valid(cpu_valid),
      .cpu_ready(cpu_ready), .cpu_laddr(cpu_laddr), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_paddr(mem_paddr), .trap_pulse(trap_pulse),
      .trap_laddr(trap_laddr)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input bit priv, input bit sel, input logic [PW-1:0] d);
      @(negedge clk);
      priv_mode = priv; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; priv_mode = 1'b0;
   endtask

   // Issue one request, check the result one cycle later, then idle one cycle.
   task automatic issue(input logic [LW-1:0] a, input bit expect_trap,
                        input logic [PW-1:0] exp_pa, input string req);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_laddr = a;
      @(posedge clk); #1;
      if (expect_trap) begin
         chk(trap_pulse == 1'b1, req, trap_pulse, 1);
         chk(trap_laddr == a, req, trap_laddr, a);
         chk(mem_valid == 1'b0, req, mem_valid, 0);
      end else begin
         chk(mem_valid == 1'b1, req, mem_valid, 1);
         chk(mem_paddr == exp_pa, req, mem_paddr, exp_pa);
         chk(trap_pulse == 1'b0, req, trap_pulse, 0);
      end
      @(negedge clk);
      cpu_valid = 1'b0;
      @(posedge clk); #1;
      chk(trap_pulse == 1'b0, "R3 trap lasts one cycle", trap_pulse, 0);
   endtask

   task automatic t_reset();
      #1;
      chk(cpu_ready == 1'b1, "R1 ready", cpu_ready, 1);
      chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
      chk(trap_pulse == 1'b0, "R1 trap", trap_pulse, 0);
      issue(16'h0000, 1'b1, '0, "R1 reset limit traps");
   endtask

   task automatic t_legal_bound();
      cfg_write(1'b1, 1'b0, 20'h01000);
      cfg_write(1'b1, 1'b1, 20'h00100);
      issue(16'h0000, 1'b0, 20'h01000, "R2 R4 low address");
      issue(16'h00FF, 1'b0, 20'h010FF, "R2 last legal address");
      issue(16'h0100, 1'b1, '0, "R3 equal to limit");
      issue(16'h8000, 1'b1, '0, "R3 far above limit");
   endtask

   task automatic t_user_ignored();
      cfg_write(1'b0, 1'b0, 20'h05000);
      issue(16'h0010, 1'b0, 20'h01010, "R6 user base write ignored");
      cfg_write(1'b0, 1'b1, 20'h0FFFF);
      issue(16'h0100, 1'b1, '0, "R6 user limit write ignored");
   endtask

   task automatic t_wrap();
      cfg_write(1'b1, 1'b0, 20'hFFFF0);
      issue(16'h0020, 1'b0, 20'h00010, "R8 wrap modulo");
   endtask

   task automatic t_same_cycle();
      cfg_write(1'b1, 1'b0, 20'h02000);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_laddr = 16'h0010;
      priv_mode = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 20'h03000;
      @(posedge clk); #1;
      chk(mem_paddr == 20'h02010, "R7 old base used", mem_paddr, 20'h02010);
      @(negedge clk);
      cpu_valid = 1'b0; cfg_we = 1'b0; priv_mode = 1'b0;
      @(posedge clk); #1;
      issue(16'h0010, 1'b0, 20'h03010, "R7 new base next request");
   endtask

   task automatic t_stall();
      @(negedge clk);
      mem_ready = 1'b0; cpu_valid = 1'b1; cpu_laddr = 16'h0005;
      @(posedge clk); #1;
      chk(mem_valid == 1'b1, "R5 request out", mem_valid, 1);
      @(negedge clk);
      cpu_laddr = 16'h0006;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #1;
         chk(cpu_ready == 1'b0, "R5 cpu stalled", cpu_ready, 0);
         chk(mem_paddr == 20'h03005, "R5 address held", mem_paddr, 20'h03005);
      end
      @(negedge clk);
      mem_ready = 1'b1;
      @(posedge clk); #1;
      chk(mem_valid == 1'b1 && mem_paddr == 20'h03006, "R5 queued request after stall",
          mem_paddr, 20'h03006);
      @(negedge clk);
      cpu_valid = 1'b0;
      @(posedge clk); #1;
      chk(mem_valid == 1'b0, "R5 drained", mem_valid, 0);
   endtask

   task automatic t_throughput();
      logic [LW-1:0] seq [4] = '{16'h0001, 16'h0200, 16'h0003, 16'h0004};
      mem_ready = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         cpu_valid = 1'b1; cpu_laddr = seq[i];
         @(posedge clk); #1;
         if (seq[i] == 16'h0200) begin
            chk(trap_pulse == 1'b1 && trap_laddr == 16'h0200, "R9 R3 trap in stream",
                trap_laddr, 16'h0200);
            chk(mem_valid == 1'b0, "R9 R3 no request for trap", mem_valid, 0);
         end else begin
            chk(mem_valid == 1'b1 && mem_paddr == 20'h03000 + seq[i], "R9 back to back",
                mem_paddr, 20'h03000 + seq[i]);
            chk(trap_pulse == 1'b0, "R9 no trap", trap_pulse, 0);
         end
         @(negedge clk);
      end
      cpu_valid = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_legal_bound();
      t_user_ignored();
      t_wrap();
      t_same_cycle();
      t_stall();
      t_throughput();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule